// File: doc/BRIEF.md
# Load Dependency Interlock for an In-Order Integer Pipeline

This block is the issue-control logic of a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory access and write-back. The memory-access stage does not block on loads. One load may be outstanding at a time, and its data may take any number of cycles to come back. While that load waits, younger instructions that do not touch its target register keep moving through execute, memory access and write-back. Such an instruction can therefore retire before the load does.

Each cycle the block compares the instruction sitting in decode with the pending load's destination register. Each source field and the destination field has its own enable bit. Decode is held only in three cases: a source reads the pending register (true dependency), the destination equals it (write-after-write), or the instruction is itself a load (only one load may be in flight). The hold drops in the same cycle the load data arrives. In that cycle the data is forwarded to the operand that needed it. The returned value is written through a dedicated second register-file write port, so it never competes with the ALU write-back.

Top module: `ldhaz_ctrl`

## Requirements
- R1: After reset `ld_busy`, `id_stall` and `rf_we1` are all 0.
- R2: A load leaves decode when `id_valid=1`, `id_is_load=1` and `id_stall=0`. From the next cycle `ld_busy` is 1, and it stays 1 for as many cycles as `ld_ret_valid` stays low. No fixed latency is assumed.
- R3: While a load is pending and no data returns, a valid decode instruction with an enabled source field equal to the pending destination gets `id_stall=1`.
- R4: While a load is pending, a valid decode instruction whose enabled fields all differ from the pending destination, and which is not a load, gets `id_stall=0`. Disabled fields never cause a stall.
- R5: While a load is pending and no data returns, a valid instruction with an enabled destination equal to the pending destination gets `id_stall=1`.
- R6: While a load is pending and no data returns, a valid load in decode gets `id_stall=1`.
- R7: In a cycle with `ld_ret_valid=1` and a load pending, `id_stall=0`. For every source i that is enabled and equal to the pending destination, `fwd_src[i]=1`, and `fwd_data` equals `ld_ret_data`.
- R8: In that cycle `rf_we1=1`, `rf_waddr1` is the pending destination and `rf_wdata1=ld_ret_data`. On the next cycle `ld_busy=0`, unless a new load issued in the same cycle.
- R9: The ALU write-back port (`rf_we0`, `rf_waddr0`, `rf_wdata0`) follows `alu_wb_*` unchanged in every cycle, including cycles where port 1 also writes.
- R10: `ld_ret_valid` with no load pending is ignored: `rf_we1=0`, no forwarding, and `ld_busy` stays 0.
- R11: With `id_valid=0`, `id_stall=0`.
- R12: A load may issue in the cycle the previous load returns. `ld_busy` then stays 1, now tracking the new load's destination. The data coming back one cycle after issue lets a dependent instruction pass with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_is_load | input | 1 | Decode instruction is a load |
| id_src_en | input | NSRC (2) | Per-source operand enable |
| id_src_idx | input | NSRC*REG_AW (8) | Source register indices, source i at bits [i*REG_AW +: REG_AW] |
| id_rd_en | input | 1 | Decode instruction writes a register |
| id_rd | input | REG_AW (4) | Decode destination register |
| ld_ret_valid | input | 1 | Load data returns this cycle |
| ld_ret_data | input | DATA_W (32) | Returned load data |
| alu_wb_valid | input | 1 | ALU result reaches write-back |
| alu_wb_rd | input | REG_AW (4) | ALU write-back register |
| alu_wb_data | input | DATA_W (32) | ALU write-back value |
| id_stall | output | 1 | Hold decode and everything behind it |
| ld_busy | output | 1 | A load is outstanding |
| fwd_src | output | NSRC (2) | Source i takes `fwd_data` this cycle |
| fwd_data | output | DATA_W (32) | Forwarded load value |
| rf_we0 | output | 1 | Write port 0 enable (ALU) |
| rf_waddr0 | output | REG_AW (4) | Write port 0 address |
| rf_wdata0 | output | DATA_W (32) | Write port 0 data |
| rf_we1 | output | 1 | Write port 1 enable (load return) |
| rf_waddr1 | output | REG_AW (4) | Write port 1 address |
| rf_wdata1 | output | DATA_W (32) | Write port 1 data |

## Verification
A wrong pending flag or a stale captured destination shows up at the ports in the first cycle a decode instruction names that register. A stall is missing or spurious, or port 1 writes the wrong address at the next return. A tracker that fails to clear shows within one cycle of a return as `ld_busy` stuck high, and the next load then stalls. The random phase keeps register indices in a small range, so matches and near misses occur often. The directed cases hit the return-cycle release, a stray return, and a load issuing in the same cycle as a return.

// File: rtl/ldhaz_pkg.sv
// Shared definitions for the load dependency interlock.
// Assumes a single outstanding load and a decode stage that presents
// per-field enables alongside register indices.
package ldhaz_pkg;
    // Reason the decode stage is held; NONE means it may advance.
    typedef enum logic [1:0] {
        HZ_NONE   = 2'd0,
        HZ_RAW    = 2'd1,
        HZ_WAW    = 2'd2,
        HZ_SECOND = 2'd3
    } hz_cause_t;
endpackage

// File: rtl/ldhaz_track.sv
// Outstanding-load tracker. Holds one busy flag and the destination of the
// load in flight. Assumes issue is already qualified by the stall logic and
// that returns arriving while idle must be dropped.
module ldhaz_track #(
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [REG_AW-1:0] issue_rd,
    input  logic              ret_valid,
    output logic              busy,
    output logic [REG_AW-1:0] pend_rd,
    output logic              ret_take
);
    // A return only counts when a load is actually waiting for it.
    always_comb ret_take = busy & ret_valid;

    // Set on issue, clear on accepted return; issue wins on a shared cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            pend_rd <= '0;
        end else begin
            if (issue) begin
                busy    <= 1'b1;
                pend_rd <= issue_rd;
            end else if (ret_take) begin
                busy    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ldhaz_cmp.sv
// Register comparators between the decode fields and the pending load's
// destination. One comparator per source field, generated from NSRC, plus
// one for the destination. Disabled fields never report a match.
module ldhaz_cmp #(
    parameter int REG_AW = 4,
    parameter int NSRC   = 2
) (
    input  logic                   busy,
    input  logic [REG_AW-1:0]      pend_rd,
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC*REG_AW-1:0] src_idx,
    input  logic                   rd_en,
    input  logic [REG_AW-1:0]      rd,
    output logic [NSRC-1:0]        src_hit,
    output logic                   rd_hit
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        // Source i reads the register the pending load will write.
        always_comb src_hit[i] = busy & src_en[i] &
                                 (src_idx[i*REG_AW +: REG_AW] == pend_rd);
    end

    // Destination collides with the pending load's destination.
    always_comb rd_hit = busy & rd_en & (rd == pend_rd);
endmodule

// File: rtl/ldhaz_wb.sv
// Write-back port steering. Port 0 carries ALU results unchanged; port 1 is
// reserved for load returns, so the two never contend for one port.
// Assumes the interlock keeps the two addresses distinct.
module ldhaz_wb #(
    parameter int REG_AW = 4,
    parameter int DATA_W = 32
) (
    input  logic              alu_valid,
    input  logic [REG_AW-1:0] alu_rd,
    input  logic [DATA_W-1:0] alu_data,
    input  logic              ld_take,
    input  logic [REG_AW-1:0] ld_rd,
    input  logic [DATA_W-1:0] ld_data,
    output logic              we0,
    output logic [REG_AW-1:0] waddr0,
    output logic [DATA_W-1:0] wdata0,
    output logic              we1,
    output logic [REG_AW-1:0] waddr1,
    output logic [DATA_W-1:0] wdata1
);
    // Drive both ports from their own sources with no arbitration.
    always_comb begin
        we0    = alu_valid;
        waddr0 = alu_rd;
        wdata0 = alu_data;
        we1    = ld_take;
        waddr1 = ld_rd;
        wdata1 = ld_data;
    end
endmodule

// File: rtl/ldhaz_ctrl.sv
// Top of the non-blocking load interlock. Decides each cycle whether the
// decode instruction may advance, forwards returning load data to a held
// operand, and drives the two register-file write ports. Assumes at most
// one load outstanding and that memory returns data for it exactly once.
module ldhaz_ctrl
    import ldhaz_pkg::*;
#(
    parameter int REG_AW = 4,
    parameter int DATA_W = 32,
    parameter int NSRC   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   id_valid,
    input  logic                   id_is_load,
    input  logic [NSRC-1:0]        id_src_en,
    input  logic [NSRC*REG_AW-1:0] id_src_idx,
    input  logic                   id_rd_en,
    input  logic [REG_AW-1:0]      id_rd,
    input  logic                   ld_ret_valid,
    input  logic [DATA_W-1:0]      ld_ret_data,
    input  logic                   alu_wb_valid,
    input  logic [REG_AW-1:0]      alu_wb_rd,
    input  logic [DATA_W-1:0]      alu_wb_data,
    output logic                   id_stall,
    output logic                   ld_busy,
    output logic [NSRC-1:0]        fwd_src,
    output logic [DATA_W-1:0]      fwd_data,
    output logic                   rf_we0,
    output logic [REG_AW-1:0]      rf_waddr0,
    output logic [DATA_W-1:0]      rf_wdata0,
    output logic                   rf_we1,
    output logic [REG_AW-1:0]      rf_waddr1,
    output logic [DATA_W-1:0]      rf_wdata1
);
    logic              busy;
    logic [REG_AW-1:0] pend_rd;
    logic              ret_take;
    logic              issue;
    logic [NSRC-1:0]   src_hit;
    logic              rd_hit;
    hz_cause_t         cause;

    ldhaz_track #(.REG_AW(REG_AW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .issue_rd (id_rd),
        .ret_valid(ld_ret_valid),
        .busy     (busy),
        .pend_rd  (pend_rd),
        .ret_take (ret_take)
    );

    ldhaz_cmp #(.REG_AW(REG_AW), .NSRC(NSRC)) u_cmp (
        .busy    (busy),
        .pend_rd (pend_rd),
        .src_en  (id_src_en),
        .src_idx (id_src_idx),
        .rd_en   (id_rd_en),
        .rd      (id_rd),
        .src_hit (src_hit),
        .rd_hit  (rd_hit)
    );

    // Classify the hazard; a returning load resolves all of them at once.
    always_comb begin
        cause = HZ_NONE;
        if (id_valid && busy && !ret_take) begin
            if (|src_hit)        cause = HZ_RAW;
            else if (rd_hit)     cause = HZ_WAW;
            else if (id_is_load) cause = HZ_SECOND;
        end
    end

    // Stall, issue qualification, busy view and forwarding selects.
    always_comb begin
        id_stall = (cause != HZ_NONE);
        issue    = id_valid & id_is_load & ~id_stall;
        ld_busy  = busy;
        fwd_src  = ret_take ? src_hit : '0;
        fwd_data = ld_ret_data;
    end

    ldhaz_wb #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_wb (
        .alu_valid(alu_wb_valid),
        .alu_rd   (alu_wb_rd),
        .alu_data (alu_wb_data),
        .ld_take  (ret_take),
        .ld_rd    (pend_rd),
        .ld_data  (ld_ret_data),
        .we0      (rf_we0),
        .waddr0   (rf_waddr0),
        .wdata0   (rf_wdata0),
        .we1      (rf_we1),
        .waddr1   (rf_waddr1),
        .wdata1   (rf_wdata1)
    );
endmodule

// File: rtl/ldhaz_ctrl_chk.sv
// Property checker for ldhaz_ctrl, attached by bind. Observes ports only.
module ldhaz_ctrl_chk #(
    parameter int NSRC = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid,
    input logic            id_is_load,
    input logic            ld_ret_valid,
    input logic            id_stall,
    input logic            ld_busy,
    input logic [NSRC-1:0] fwd_src,
    input logic            rf_we1
);
    // R2: pending load persists until data comes back.
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_busy && !ld_ret_valid) |=> ld_busy);

    // R4: no stall can occur without a pending load.
    assert_stall_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        id_stall |-> ld_busy);

    // R6: a second load waits while the first is outstanding.
    assert_second_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_busy && id_valid && id_is_load && !ld_ret_valid) |-> id_stall);

    // R7: the return cycle always releases decode.
    assert_release_on_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_busy && ld_ret_valid) |-> !id_stall);

    // R8: a return with no new load clears the tracker.
    assert_clear_after_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_busy && ld_ret_valid && !(id_valid && id_is_load)) |=> !ld_busy);

    // R10: stray return neither writes nor forwards.
    assert_stray_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_busy |-> (!rf_we1 && fwd_src == '0));

    // R11: an empty decode slot never stalls.
    assert_idle_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !id_stall);
endmodule

bind ldhaz_ctrl ldhaz_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_is_load  (id_is_load),
    .ld_ret_valid(ld_ret_valid),
    .id_stall    (id_stall),
    .ld_busy     (ld_busy),
    .fwd_src     (fwd_src),
    .rf_we1      (rf_we1)
);

// File: tb/ldhaz_ctrl_bench.sv
// Bench for ldhaz_ctrl: directed corner cases, then seeded random traffic
// checked against a requirement-level model of the pending load.
module ldhaz_ctrl_bench;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid = 0, id_is_load = 0, id_rd_en = 0;
    logic [NS-1:0] id_src_en = '0;
    logic [NS*AW-1:0] id_src_idx = '0;
    logic [AW-1:0] id_rd = '0;
    logic ld_ret_valid = 0;
    logic [DW-1:0] ld_ret_data = '0;
    logic alu_wb_valid = 0;
    logic [AW-1:0] alu_wb_rd = '0;
    logic [DW-1:0] alu_wb_data = '0;
    logic id_stall, ld_busy, rf_we0, rf_we1;
    logic [NS-1:0] fwd_src;
    logic [DW-1:0] fwd_data, rf_wdata0, rf_wdata1;
    logic [AW-1:0] rf_waddr0, rf_waddr1;

    int n_chk = 0, n_fail = 0;
    bit m_busy = 0;
    logic [AW-1:0] m_rd = '0;
    bit done = 0;

    always #4 clk = ~clk;

    ldhaz_ctrl u_ldhaz_ctrl (.*);

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic bit src_match(input int i);
        return m_busy && id_src_en[i] && id_src_idx[i*AW +: AW] == m_rd;
    endfunction

    function automatic bit exp_stall();
        bit hz = 0;
        for (int i = 0; i < NS; i++) hz |= src_match(i);
        hz |= (id_rd_en && id_rd == m_rd);
        hz |= id_is_load;
        return id_valid && m_busy && !ld_ret_valid && hz;
    endfunction

    // Apply current inputs, compare all outputs, then advance one clock.
    task automatic step();
        bit es, take;
        logic [NS-1:0] ef;
        #1;
        es = exp_stall();
        take = m_busy && ld_ret_valid;
        for (int i = 0; i < NS; i++) ef[i] = take && src_match(i);
        chk(ld_busy == m_busy, "R2 ld_busy", ld_busy, m_busy);
        chk(id_stall == es, "R3 id_stall", id_stall, es);
        chk(fwd_src == ef, "R7 fwd_src", fwd_src, ef);
        if (take) chk(fwd_data == ld_ret_data, "R7 fwd_data", fwd_data, ld_ret_data);
        chk(rf_we1 == take, "R10 rf_we1", rf_we1, take);
        if (take) begin
            chk(rf_waddr1 == m_rd, "R8 rf_waddr1", rf_waddr1, m_rd);
            chk(rf_wdata1 == ld_ret_data, "R8 rf_wdata1", rf_wdata1, ld_ret_data);
        end
        chk(rf_we0 == alu_wb_valid && rf_waddr0 == alu_wb_rd && rf_wdata0 == alu_wb_data,
            "R9 port0", {rf_we0, rf_waddr0}, {alu_wb_valid, alu_wb_rd});
        @(posedge clk);
        if (id_valid && id_is_load && !es) begin
            m_busy = 1; m_rd = id_rd;
        end else if (take) m_busy = 0;
        @(negedge clk);
    endtask

    task automatic set_id(input bit v, input bit ld, input logic [NS-1:0] se,
                          input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                          input bit re, input logic [AW-1:0] rd);
        id_valid = v; id_is_load = ld; id_src_en = se;
        id_src_idx = {s1, s0}; id_rd_en = re; id_rd = rd;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!ld_busy && !id_stall && !rf_we1, "R1 reset state", {ld_busy, id_stall, rf_we1}, 0);
        rst_n = 1;
        @(negedge clk);

        // R10: stray return while idle
        ld_ret_valid = 1; ld_ret_data = 32'hDEAD0001;
        set_id(1, 0, 2'b01, 4'd3, 4'd0, 1, 4'd4);
        #1; chk(!rf_we1 && fwd_src == 0, "R10 stray return", rf_we1, 0);
        step();
        ld_ret_valid = 0;

        // R2: issue load to r5, then hold for several cycles
        set_id(1, 1, 2'b01, 4'd1, 4'd0, 1, 4'd5); step();
        // R4: independent instruction flows past
        set_id(1, 0, 2'b11, 4'd1, 4'd2, 1, 4'd3);
        #1; chk(!id_stall && ld_busy, "R4 independent passes", id_stall, 0); step();
        // R4: disabled field equal to r5 is harmless
        set_id(1, 0, 2'b01, 4'd2, 4'd5, 0, 4'd5);
        #1; chk(!id_stall, "R4 disabled fields", id_stall, 0); step();
        // R3: second source reads r5
        set_id(1, 0, 2'b10, 4'd0, 4'd5, 1, 4'd6);
        #1; chk(id_stall, "R3 raw stall", id_stall, 1); step();
        // R5: writes r5
        set_id(1, 0, 2'b00, 4'd0, 4'd0, 1, 4'd5);
        #1; chk(id_stall, "R5 waw stall", id_stall, 1); step();
        // R6: second load
        set_id(1, 1, 2'b01, 4'd1, 4'd0, 1, 4'd7);
        #1; chk(id_stall, "R6 second load", id_stall, 1); step();
        // R11: empty slot
        set_id(0, 0, 2'b01, 4'd5, 4'd0, 1, 4'd5);
        #1; chk(!id_stall, "R11 invalid no stall", id_stall, 0); step();
        // R7/R8/R9: return with dependent held and ALU write same cycle
        set_id(1, 0, 2'b01, 4'd5, 4'd0, 1, 4'd8);
        ld_ret_valid = 1; ld_ret_data = 32'h1234_5678;
        alu_wb_valid = 1; alu_wb_rd = 4'd3; alu_wb_data = 32'hA5A5_0003;
        #1;
        chk(!id_stall && fwd_src == 2'b01 && fwd_data == 32'h1234_5678, "R7 release+forward",
            {id_stall, fwd_src}, 2'b01);
        chk(rf_we1 && rf_waddr1 == 4'd5 && rf_we0 && rf_waddr0 == 4'd3, "R9 two ports",
            {rf_we1, rf_waddr1, rf_we0, rf_waddr0}, {1'b1, 4'd5, 1'b1, 4'd3});
        step();
        ld_ret_valid = 0; alu_wb_valid = 0;
        set_id(0, 0, 0, 0, 0, 0, 0);
        #1; chk(!ld_busy, "R8 busy clears", ld_busy, 0); step();

        // R12: load r2, return next cycle with dependent and a new load r9
        set_id(1, 1, 2'b00, 0, 0, 1, 4'd2); step();
        set_id(1, 1, 2'b01, 4'd2, 4'd0, 1, 4'd9);
        ld_ret_valid = 1; ld_ret_data = 32'h0000_0022;
        #1; chk(!id_stall && fwd_src[0], "R12 back-to-back load", id_stall, 0); step();
        ld_ret_valid = 0;
        set_id(1, 0, 2'b01, 4'd9, 4'd0, 1, 4'd1);
        #1; chk(ld_busy && id_stall, "R12 tracks new load", {ld_busy, id_stall}, 2'b11); step();
        ld_ret_valid = 1; step();
        ld_ret_valid = 0;

        // Random phase, fixed seed, small register range for frequent matches
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            set_id($urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0,
                   NS'($urandom), AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
                   $urandom_range(0, 3) != 0, AW'($urandom_range(0, 3)));
            ld_ret_valid = $urandom_range(0, 3) == 0;
            ld_ret_data  = $urandom;
            alu_wb_valid = $urandom_range(0, 1);
            alu_wb_rd    = AW'($urandom);
            alu_wb_data  = $urandom;
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule